// File: doc/BRIEF.md
# Floating-Point Compare Exception Flag Unit

This block receives two IEEE 754 single-precision operands and works out which IEEE exceptions an ordered "a less than or equal to b" comparison would raise. It does not report whether the relation holds. It returns a 32-bit integer flag word. A NaN operand of either kind, quiet or signalling, raises the invalid flag. A denormal operand is treated as zero for the comparison and raises the flushed-to-zero flag. Every other operand pair gives an all-zero word. Because an ordered compare raises the same flags in either operand order, the same unit also serves the greater-or-equal form with the operands exchanged.

An operation enters through a valid/ready handshake on the input side. It is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. One cycle later the result is presented on the output side with `out_valid`. The issue carries a guard word, and only its least significant bit matters. When that bit is 1, the accepted result is written into the destination register that drives `out_flags`. When it is 0, the destination keeps its earlier contents, but `out_valid` still marks the completed operation.

Back-pressure works as follows. While `out_valid` is high and `out_ready` is low, the output is stalled: `out_valid` and `out_flags` hold and `in_ready` is low. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. The unit has no global status of its own.

Top module: `fpcmp_flags_top`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and the destination (`out_flags`) is 0.
- R2: A NaN operand raises bit 4 (invalid, value 0x10). A NaN has an exponent field [30:23] of all ones and a nonzero mantissa [22:0]. This holds whatever the sign and whether the NaN is quiet or signalling.
- R3: A denormal operand raises bit 5 (flushed-to-zero, value 0x20). A denormal has an exponent field of zero and a nonzero mantissa.
- R4: When one operand is a NaN and the other is denormal, the result is 0x30.
- R5: Operand pairs made only of zeros, normal numbers and infinities of either sign give 0. This covers equal values, +INF against -INF and +INF against itself.
- R6: Bits 0 to 3 and 6 to 31 of `out_flags` are always 0.
- R7: An accepted operation writes the destination only when guard bit 0 is 1. Otherwise `out_flags` keeps its previous value.
- R8: `out_valid` is high in the cycle after each accepted operation.
- R9: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_flags` stay unchanged.
- R10: Exchanging the two operands gives the same flag word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The unit can take an operation this cycle |
| op_a | input | 32 | Left operand, single precision |
| op_b | input | 32 | Right operand, single precision |
| guard | input | 32 | Write enable word; only bit 0 is used |
| out_valid | output | 1 | A completed operation is presented |
| out_ready | input | 1 | The consumer takes the presented result |
| out_flags | output | 32 | Destination register holding the exception flag word |

## Verification
The hardest case to reach from the ports is a stalled output that holds a NaN or denormal result while the next issue, with its guard bit clear, waits at the input. A flawed design could overwrite the destination or drop the pending result at that point. The random stimulus chooses each operand's class with equal weight, so NaNs and denormals are as common as normal numbers. It also drops `out_ready` about a third of the time and clears the guard bit about a quarter of the time, so stalls, blocked issues and guard-off writes meet again and again. Directed pairs cover the mixed NaN-with-denormal case, the infinities, and both operand orders.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
  localparam int FLAG_W  = 32;
  localparam int BIT_INV = 4;
  localparam int BIT_IFZ = 5;

  // Class of one operand; at most one field is set
  typedef struct packed {
    logic is_nan;
    logic is_sub;
    logic is_inf;
    logic is_zero;
  } opclass_t;
endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify
  import fpcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] value,
  output opclass_t             cls
);
  localparam int MAN_HI = MAN_W - 1;
  localparam int EXP_LO = MAN_W;
  localparam int EXP_HI = MAN_W + EXP_W - 1;

  logic exp_ones, exp_zero, man_nz;

  always_comb begin
    exp_ones    = &value[EXP_HI:EXP_LO];
    exp_zero    = ~|value[EXP_HI:EXP_LO];
    man_nz      = |value[MAN_HI:0];
    cls.is_nan  = exp_ones & man_nz;
    cls.is_inf  = exp_ones & ~man_nz;
    cls.is_sub  = exp_zero & man_nz;
    cls.is_zero = exp_zero & ~man_nz;
  end

  // R2/R3: an operand never lands in two classes
  always_comb begin
    if (!$isunknown(value))
      a_r2_class_exclusive: assert ($onehot0(cls));
  end
endmodule

// File: rtl/fpcmp_flag_merge.sv
module fpcmp_flag_merge
  import fpcmp_pkg::*;
(
  input  opclass_t          cls_a,
  input  opclass_t          cls_b,
  output logic [FLAG_W-1:0] flags
);
  always_comb begin
    flags          = '0;
    flags[BIT_INV] = cls_a.is_nan | cls_b.is_nan;
    flags[BIT_IFZ] = cls_a.is_sub | cls_b.is_sub;
  end

  // R4: a NaN beside a denormal reports both flags
  always_comb begin
    if (!$isunknown({cls_a, cls_b}) && (cls_a.is_nan && cls_b.is_sub))
      a_r4_both_flags: assert (flags[BIT_INV] && flags[BIT_IFZ]);
  end
endmodule

// File: rtl/fpcmp_flags_top.sv
module fpcmp_flags_top
  import fpcmp_pkg::*;
#(
  parameter int EXP_W   = 8,
  parameter int MAN_W   = 23,
  parameter int GUARD_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [EXP_W+MAN_W:0]   op_a,
  input  logic [EXP_W+MAN_W:0]   op_b,
  input  logic [GUARD_W-1:0]     guard,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [FLAG_W-1:0]      out_flags
);
  localparam int DATA_W = 1 + EXP_W + MAN_W;
  localparam int N_OPS  = 2;
  localparam logic [FLAG_W-1:0] USED_MASK =
    (FLAG_W'(1) << BIT_INV) | (FLAG_W'(1) << BIT_IFZ);

  logic [DATA_W-1:0] operand [N_OPS];
  opclass_t          cls     [N_OPS];
  logic [FLAG_W-1:0] flags_next;
  logic [FLAG_W-1:0] dest_q;
  logic              vld_q;
  logic              accept;

  assign operand[0] = op_a;
  assign operand[1] = op_b;

  for (genvar i = 0; i < N_OPS; i++) begin : g_cls
    fpcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .value (operand[i]),
      .cls   (cls[i])
    );
  end

  fpcmp_flag_merge u_merge (
    .cls_a (cls[0]),
    .cls_b (cls[1]),
    .flags (flags_next)
  );

  assign in_ready = !vld_q || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      dest_q <= '0;
    end else begin
      if (accept)         vld_q <= 1'b1;
      else if (out_ready) vld_q <= 1'b0;
      if (accept && guard[0]) dest_q <= flags_next;
    end
  end

  assign out_valid = vld_q;
  assign out_flags = dest_q;

  a_r8_valid_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  a_r9_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_flags)));

  a_r7_guard_off_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !guard[0]) |=> $stable(out_flags));

  a_r6_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_flags & ~USED_MASK) == '0);
endmodule

// File: tb/fpcmp_flags_top_test.sv
`timescale 1ns/1ps
module fpcmp_flags_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] op_a = '0, op_b = '0, guard = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_flags;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  logic        m_ov = 1'b0;
  logic [31:0] m_dest = '0;
  string       m_tag = "R1";

  always #4 clk = ~clk;

  fpcmp_flags_top uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .guard(guard), .out_valid(out_valid),
    .out_ready(out_ready), .out_flags(out_flags)
  );

  function automatic bit is_nan(input logic [31:0] x);
    return (x[30:23] == 8'hff) && (x[22:0] != 0);
  endfunction
  function automatic bit is_den(input logic [31:0] x);
    return (x[30:23] == 8'h00) && (x[22:0] != 0);
  endfunction
  function automatic logic [31:0] exp_flags(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] f = '0;
    if (is_nan(a) || is_nan(b)) f[4] = 1'b1;
    if (is_den(a) || is_den(b)) f[5] = 1'b1;
    return f;
  endfunction
  function automatic string tag_of(input logic [31:0] f);
    if (f == 32'h30) return "R4";
    if (f == 32'h10) return "R2";
    if (f == 32'h20) return "R3";
    return "R5";
  endfunction
  // class: 0 zero, 1 denormal, 2 normal, 3 inf, 4 nan
  function automatic logic [31:0] mk(input int c, input logic s, input logic [31:0] r);
    case (c)
      0:       return {s, 31'd0};
      1:       return {s, 8'h00, r[22:0] | 23'd1};
      2:       return {s, 8'(1 + (r[31:24] % 254)), r[22:0]};
      3:       return {s, 8'hff, 23'd0};
      default: return {s, 8'hff, r[22:0] | 23'd1};
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] a, input logic [31:0] b,
                      input logic [31:0] g, input logic rdy, input string tag);
    logic [31:0] e;
    check(out_valid === m_ov, "R8", "out_valid", 32'(out_valid), 32'(m_ov));
    if (m_ov) begin
      check(out_flags === m_dest, m_tag, "out_flags", out_flags, m_dest);
      check((out_flags & ~32'h30) == 0, "R6", "unused bits", out_flags, 32'h0);
    end
    out_ready = rdy; in_valid = v; op_a = a; op_b = b; guard = g;
    #1;
    check(in_ready === (!m_ov || rdy), "R9", "in_ready", 32'(in_ready), 32'(!m_ov || rdy));
    if (v && (!m_ov || rdy)) begin
      m_ov = 1'b1;
      if (g[0]) begin
        e = exp_flags(a, b);
        m_dest = e;
        m_tag = (tag != "") ? tag : tag_of(e);
      end else m_tag = "R7";
    end else if (rdy) m_ov = 1'b0;
    @(negedge clk);
  endtask

  task automatic pair(input logic [31:0] a, input logic [31:0] b);
    step(1, a, b, 1, 1, "");
    step(1, b, a, 1, 1, "R10");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk); @(negedge clk);
    check(out_valid === 1'b0, "R1", "reset valid", 32'(out_valid), 0);
    check(out_flags === 32'h0, "R1", "reset dest", out_flags, 0);
    rst_n = 1'b1;
    // directed corner cases
    pair(32'h40400000, 32'h00000000);
    pair(32'h40400000, 32'h40400000);
    pair(32'h40400000, 32'hffffffff);
    pair(32'h7f800000, 32'hff800000);
    pair(32'h3f800000, 32'h00400000);
    pair(32'h7f800000, 32'h7f800000);
    pair(32'h7fc00000, 32'h80000001);
    pair(32'h7f800001, 32'h3f800000);
    pair(32'h80000000, 32'h00000000);
    step(1, 32'h7fc00000, 32'h0, 1, 1, "");
    step(1, 32'h3f800000, 32'h00400000, 0, 1, "");  // guard off: keep 0x10
    step(1, 32'h3f800000, 32'h00400000, 32'hfffffffe, 0, "");
    step(1, 32'h00000001, 32'h0, 1, 0, "");          // blocked while stalled
    step(0, 0, 0, 0, 1, "");
    step(0, 0, 0, 0, 1, "");
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, b, g;
      a = mk(int'($urandom % 5), 1'($urandom), $urandom);
      b = mk(int'($urandom % 5), 1'($urandom), $urandom);
      g = (($urandom % 4) == 0) ? ($urandom & 32'hfffffffe) : ($urandom | 32'h1);
      step(1'(($urandom % 4) != 0), a, b, g, 1'(($urandom % 3) != 0), "");
    end
    step(0, 0, 0, 0, 1, "");
    step(0, 0, 0, 0, 1, "");
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule